// File: doc/BRIEF.md
# Per-Frame Correlation Peak Searcher

This block sits behind a synchronization-sequence correlator in an OFDM receiver. Every clock it may accept one correlation magnitude, marked by a valid strobe, together with the signal energy measured over the correlator span. It scales that energy by a programmable fixed-point factor to form a detection threshold. It then looks for the largest correlation sample above the threshold inside fixed-length search windows. The default window is 5760 valid samples, which matches one frame at an FFT length of 128.

When a window closes, the block reports three things: whether any sample qualified, the winning magnitude, and the winning sample's position counted from the window start. That position is the frame timing offset. The block also raises a one-cycle done strobe. A hold input keeps the search idle while carrier frequency offset estimation is still running. When hold is released, a fresh window starts.

Top module: `corr_peak_search`

## Requirements
- R1: After every WIN_LEN valid, unheld samples a window closes, `search_done` pulses, and the next valid sample opens a new window at index 0.
- R2: The threshold is `(energy_in * thr_scale) >> THR_SHIFT`, taken from the energy presented with the same sample. A sample can qualify only if its correlation is strictly greater than this threshold.
- R3: A qualifying sample replaces the current peak only if it is strictly greater than the running maximum. When values are equal, the earlier index is kept.
- R4: `timing_offset` is the zero-based index of the peak, counting only valid samples from the window start.
- R5: Samples with `corr_vld` low do not advance the window index and are never peak candidates, whatever their value.
- R6: While `search_hold` is high, no sample advances the window, none is a candidate, and no done pulse occurs. The window index returns to 0, so the first valid sample after release is index 0.
- R7: The running maximum and the found state are cleared at each window start, so a large peak in one window has no effect on the next window.
- R8: If no sample in a window exceeds the threshold, the report has `peak_found` = 0, `peak_value` = 0 and `timing_offset` = 0.
- R9: `search_done` is high for exactly one cycle. The three report outputs change only together with a done pulse and hold their values otherwise.
- R10: Synchronous active-low reset clears all report outputs to 0, clears `search_done`, and restarts the window at index 0.
- R11: The report and done pulse appear after the second rising clock edge following the presentation of a window's last sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| corr_in | input | CORR_W | Correlation magnitude, unsigned |
| corr_vld | input | 1 | Marks corr_in and energy_in as a valid sample |
| energy_in | input | ENERGY_W | Signal energy over the correlator span, unsigned |
| thr_scale | input | SCALE_W | Threshold scale factor with THR_SHIFT fraction bits |
| search_hold | input | 1 | Suspends the search and restarts the window |
| timing_offset | output | OFS_W | Index of the peak within the last window |
| peak_value | output | CORR_W | Magnitude of the peak in the last window |
| peak_found | output | 1 | Some sample in the last window exceeded the threshold |
| search_done | output | 1 | One-cycle pulse when a window report is issued |

## Verification
The hardest condition to reach from the ports is a window whose boundary is shifted by something other than plain sample count. This happens when hold is raised partway through a window, or when invalid strobes carrying large values are interleaved with valid ones. The bench builds such windows on purpose. It presents a partial window, holds the search across more samples than a whole window, and then releases it. It also mixes very large invalid samples between valid ones. Then it checks that the reported offset is counted from the release and that the invalid values never win. Ties, threshold-equal samples and a large peak followed by a weaker window are placed in back-to-back table rows. This exposes any maximum that is not reset at the window boundary.

// File: rtl/psrch_pkg.sv
// Shared helpers for the correlation peak searcher.
// Assumes: window lengths of at least 1.
package psrch_pkg;

    // Bits needed to index a window of n samples (never less than 1).
    function automatic int idx_bits(input int n);
        int b;
        b = $clog2(n);
        return (b < 1) ? 1 : b;
    endfunction

endpackage

// File: rtl/psrch_thresh.sv
// Input stage: registers one sample and forms its detection threshold
// from the scaled energy, so the compare downstream sees a registered
// product. Assumes unsigned energy and a scale with THR_SHIFT fraction bits.
module psrch_thresh #(
    parameter int CORR_W    = 16,
    parameter int ENERGY_W  = 16,
    parameter int SCALE_W   = 8,
    parameter int THR_SHIFT = 4,
    localparam int PROD_W   = ENERGY_W + SCALE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CORR_W-1:0]   corr_in,
    input  logic                corr_vld,
    input  logic [ENERGY_W-1:0] energy_in,
    input  logic [SCALE_W-1:0]  scale_in,
    input  logic                hold_in,
    output logic                s_vld,
    output logic                s_hold,
    output logic [CORR_W-1:0]   s_corr,
    output logic [PROD_W-1:0]   s_thr
);

    logic [PROD_W-1:0] product;

    // Full-width product of energy and scale.
    always_comb begin
        product = PROD_W'(energy_in) * PROD_W'(scale_in);
    end

    // Capture the sample, its strobes and its shifted threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_vld  <= 1'b0;
            s_hold <= 1'b0;
            s_corr <= '0;
            s_thr  <= '0;
        end else begin
            s_vld  <= corr_vld;
            s_hold <= hold_in;
            s_corr <= corr_in;
            s_thr  <= product >> THR_SHIFT;
        end
    end

endmodule

// File: rtl/psrch_window.sv
// Window position counter: counts valid, unheld samples from 0 to
// WIN_LEN-1 and wraps. Hold forces it back to 0. Assumes WIN_LEN >= 2.
module psrch_window
    import psrch_pkg::*;
#(
    parameter int WIN_LEN = 5760,
    localparam int OFS_W  = idx_bits(WIN_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_vld,
    input  logic             s_hold,
    output logic [OFS_W-1:0] idx,
    output logic             first,
    output logic             last
);

    localparam logic [OFS_W-1:0] LAST_IDX = OFS_W'(WIN_LEN - 1);
    localparam bit POW2 = ((WIN_LEN & (WIN_LEN - 1)) == 0);

    logic [OFS_W-1:0] cnt;
    logic [OFS_W-1:0] cnt_inc;
    logic             step;

    assign step  = s_vld && !s_hold;
    assign idx   = cnt;
    assign first = (cnt == '0);
    assign last  = (cnt == LAST_IDX);

    // Next index: a power-of-two length wraps by itself, others compare.
    generate
        if (POW2) begin : g_wrap_free
            assign cnt_inc = cnt + 1'b1;
        end else begin : g_wrap_cmp
            assign cnt_inc = last ? '0 : cnt + 1'b1;
        end
    endgenerate

    // Advance on each counted sample; restart under hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (s_hold) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= cnt_inc;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cnt} <= {1'b0, LAST_IDX}); // R1
    AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        s_hold |=> first); // R6
    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> first); // R1
    AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_vld && !s_hold) |=> $stable(cnt)); // R5

endmodule

// File: rtl/psrch_tracker.sv
// Peak tracker and report registers. Keeps the largest above-threshold
// correlation of the current window and its index. On the window's last
// sample it publishes the result and pulses done. Assumes WIN_LEN >= 2.
module psrch_tracker
    import psrch_pkg::*;
#(
    parameter int WIN_LEN = 5760,
    parameter int CORR_W  = 16,
    parameter int THR_W   = 24,
    localparam int OFS_W  = idx_bits(WIN_LEN),
    localparam int CMP_W  = (CORR_W > THR_W) ? CORR_W : THR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_vld,
    input  logic              s_hold,
    input  logic [CORR_W-1:0] s_corr,
    input  logic [THR_W-1:0]  s_thr,
    input  logic [OFS_W-1:0]  idx,
    input  logic              first,
    input  logic              last,
    output logic [OFS_W-1:0]  timing_offset,
    output logic [CORR_W-1:0] peak_value,
    output logic              peak_found,
    output logic              search_done
);

    localparam logic [OFS_W-1:0] LAST_IDX = OFS_W'(WIN_LEN - 1);

    logic [CORR_W-1:0] run_max;
    logic [OFS_W-1:0]  run_idx;
    logic              run_found;

    logic              take;
    logic              base_found;
    logic [CORR_W-1:0] base_max;
    logic [OFS_W-1:0]  base_idx;
    logic              above_thr;
    logic              beats_max;
    logic              cand;
    logic              nxt_found;
    logic [CORR_W-1:0] nxt_max;
    logic [OFS_W-1:0]  nxt_idx;

    assign take = s_vld && !s_hold;

    // Candidate test: above threshold and strictly above the running peak;
    // the running state counts as empty on the window's first sample.
    always_comb begin
        base_found = first ? 1'b0 : run_found;
        base_max   = base_found ? run_max : '0;
        base_idx   = base_found ? run_idx : '0;
        above_thr  = CMP_W'(s_corr) > CMP_W'(s_thr);
        beats_max  = !base_found || (s_corr > base_max);
        cand       = take && above_thr && beats_max;
        nxt_found  = base_found || cand;
        nxt_max    = cand ? s_corr : base_max;
        nxt_idx    = cand ? idx : base_idx;
    end

    // Running peak state, updated on each counted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_max   <= '0;
            run_idx   <= '0;
            run_found <= 1'b0;
        end else if (take) begin
            run_max   <= nxt_max;
            run_idx   <= nxt_idx;
            run_found <= nxt_found;
        end
    end

    // Publish the window result and pulse done on the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timing_offset <= '0;
            peak_value    <= '0;
            peak_found    <= 1'b0;
            search_done   <= 1'b0;
        end else begin
            search_done <= take && last;
            if (take && last) begin
                timing_offset <= nxt_idx;
                peak_value    <= nxt_max;
                peak_found    <= nxt_found;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        search_done |=> !search_done); // R9
    AST_RPT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !search_done |-> ($stable(timing_offset) && $stable(peak_value)
                          && $stable(peak_found))); // R9
    AST_NOFIND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !peak_found |-> (peak_value == '0 && timing_offset == '0)); // R8
    AST_OFS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, timing_offset} <= {1'b0, LAST_IDX}); // R4
    AST_HOLD_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        s_hold |=> !search_done); // R6

endmodule

// File: rtl/corr_peak_search.sv
// Top of the per-frame correlation peak searcher: an input/threshold
// register stage, a window position counter and a peak tracker with
// report registers. Assumes unsigned correlation and energy inputs.
module corr_peak_search
    import psrch_pkg::*;
#(
    parameter int WIN_LEN   = 5760,
    parameter int CORR_W    = 16,
    parameter int ENERGY_W  = 16,
    parameter int SCALE_W   = 8,
    parameter int THR_SHIFT = 4,
    localparam int OFS_W    = idx_bits(WIN_LEN),
    localparam int THR_W    = ENERGY_W + SCALE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CORR_W-1:0]   corr_in,
    input  logic                corr_vld,
    input  logic [ENERGY_W-1:0] energy_in,
    input  logic [SCALE_W-1:0]  thr_scale,
    input  logic                search_hold,
    output logic [OFS_W-1:0]    timing_offset,
    output logic [CORR_W-1:0]   peak_value,
    output logic                peak_found,
    output logic                search_done
);

    logic              s_vld;
    logic              s_hold;
    logic [CORR_W-1:0] s_corr;
    logic [THR_W-1:0]  s_thr;
    logic [OFS_W-1:0]  idx;
    logic              first;
    logic              last;

    psrch_thresh #(
        .CORR_W    (CORR_W),
        .ENERGY_W  (ENERGY_W),
        .SCALE_W   (SCALE_W),
        .THR_SHIFT (THR_SHIFT)
    ) u_thresh (
        .clk       (clk),
        .rst_n     (rst_n),
        .corr_in   (corr_in),
        .corr_vld  (corr_vld),
        .energy_in (energy_in),
        .scale_in  (thr_scale),
        .hold_in   (search_hold),
        .s_vld     (s_vld),
        .s_hold    (s_hold),
        .s_corr    (s_corr),
        .s_thr     (s_thr)
    );

    psrch_window #(
        .WIN_LEN (WIN_LEN)
    ) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .s_vld  (s_vld),
        .s_hold (s_hold),
        .idx    (idx),
        .first  (first),
        .last   (last)
    );

    psrch_tracker #(
        .WIN_LEN (WIN_LEN),
        .CORR_W  (CORR_W),
        .THR_W   (THR_W)
    ) u_tracker (
        .clk           (clk),
        .rst_n         (rst_n),
        .s_vld         (s_vld),
        .s_hold        (s_hold),
        .s_corr        (s_corr),
        .s_thr         (s_thr),
        .idx           (idx),
        .first         (first),
        .last          (last),
        .timing_offset (timing_offset),
        .peak_value    (peak_value),
        .peak_found    (peak_found),
        .search_done   (search_done)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !search_done); // R10

endmodule

// File: tb/corr_peak_search_tb.sv
`timescale 1ns/1ps
module corr_peak_search_tb;

    localparam int WIN = 8;
    localparam int CW  = 12;
    localparam int EW  = 12;
    localparam int SW  = 8;
    localparam int SH  = 4;
    localparam int OW  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] corr_in = '0;
    logic          corr_vld = 1'b0;
    logic [EW-1:0] energy_in = '0;
    logic [SW-1:0] thr_scale = 8'd16;
    logic          search_hold = 1'b0;
    logic [OW-1:0] timing_offset;
    logic [CW-1:0] peak_value;
    logic          peak_found;
    logic          search_done;

    int checks = 0;
    int errors = 0;
    int done_seen = 0;

    always #2.5 clk = ~clk;

    corr_peak_search #(
        .WIN_LEN(WIN), .CORR_W(CW), .ENERGY_W(EW), .SCALE_W(SW), .THR_SHIFT(SH)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .corr_in(corr_in), .corr_vld(corr_vld),
        .energy_in(energy_in), .thr_scale(thr_scale), .search_hold(search_hold),
        .timing_offset(timing_offset), .peak_value(peak_value),
        .peak_found(peak_found), .search_done(search_done)
    );

    always @(posedge clk) if (rst_n && search_done) done_seen++;

    // Window samples: sample i sits at bits [i*CW +: CW]; lists are written
    // from sample 7 down to sample 0. Threshold = energy*scale/16.
    typedef struct packed {
        logic [WIN*CW-1:0] c;
        logic [EW-1:0]     e;
        logic [SW-1:0]     s;
        logic              f;
        logic [CW-1:0]     pk;
        logic [OW-1:0]     off;
    } vec_t;

    localparam vec_t VECS [7] = '{
        // R2 R4: threshold 40, peak 80 at 3
        '{ {12'd1,12'd0,12'd5,12'd20,12'd80,12'd30,12'd50,12'd10}, 12'd40, 8'd16, 1'b1, 12'd80, 3'd3 },
        // R3: tie of 70 at 2 and 3 and 5, earliest kept
        '{ {12'd0,12'd0,12'd70,12'd10,12'd70,12'd70,12'd0,12'd0}, 12'd10, 8'd16, 1'b1, 12'd70, 3'd2 },
        // R8: nothing strictly above threshold 9
        '{ {12'd9,12'd2,12'd0,12'd1,12'd9,12'd3,12'd9,12'd5}, 12'd9, 8'd16, 1'b0, 12'd0, 3'd0 },
        // R4: peak on the last index
        '{ {12'd100,12'd7,12'd6,12'd5,12'd4,12'd3,12'd2,12'd1}, 12'd0, 8'd16, 1'b1, 12'd100, 3'd7 },
        // R4: peak on index 0
        '{ {12'd3,12'd3,12'd3,12'd3,12'd3,12'd3,12'd3,12'd200}, 12'd0, 8'd16, 1'b1, 12'd200, 3'd0 },
        // R7 R2: weaker window after 200; scale 0.5 -> threshold 50
        '{ {12'd0,12'd0,12'd0,12'd0,12'd40,12'd51,12'd50,12'd49}, 12'd100, 8'd8, 1'b1, 12'd51, 3'd2 },
        // R2: scale 2 -> threshold 200, only 201 passes
        '{ {12'd0,12'd0,12'd0,12'd60,12'd201,12'd200,12'd199,12'd150}, 12'd100, 8'd32, 1'b1, 12'd201, 3'd3 }
    };

    localparam string VTAG [7] = '{"R2 R4", "R3", "R8", "R4", "R4", "R7 R2", "R2"};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input int c, input logic v, input logic h);
        @(negedge clk);
        corr_in     = CW'(c);
        corr_vld    = v;
        search_hold = h;
    endtask

    task automatic run_win(input logic [WIN*CW-1:0] c);
        for (int i = 0; i < WIN; i++) put(int'(c[i*CW +: CW]), 1'b1, 1'b0);
    endtask

    // Call right after the last sample of a window was driven.
    task automatic expect_report(input string req, input int f, input int pk, input int off);
        put(0, 1'b0, 1'b0);
        check({req, " R11 done not early"}, int'(search_done), 0);
        @(negedge clk);
        check({req, " R11 done on time"}, int'(search_done), 1);
        check({req, " found"}, int'(peak_found), f);
        check({req, " peak"}, int'(peak_value), pk);
        check({req, " offset"}, int'(timing_offset), off);
        @(negedge clk);
        check({req, " R9 done one cycle"}, int'(search_done), 0);
        check({req, " R9 offset held"}, int'(timing_offset), off);
        check({req, " R9 peak held"}, int'(peak_value), pk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int d0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 offset", int'(timing_offset), 0);
        check("R10 peak", int'(peak_value), 0);
        check("R10 found", int'(peak_found), 0);
        check("R10 done", int'(search_done), 0);

        // Table of back-to-back windows (R1 continuous wrap)
        for (int r = 0; r < 7; r++) begin
            energy_in = VECS[r].e;
            thr_scale = VECS[r].s;
            run_win(VECS[r].c);
            expect_report(VTAG[r], int'(VECS[r].f), int'(VECS[r].pk), int'(VECS[r].off));
        end

        // R5: invalid samples with large values neither count nor win
        energy_in = '0; thr_scale = 8'd16;
        put(10, 1'b1, 1'b0);
        put(4000, 1'b0, 1'b0);
        put(20, 1'b1, 1'b0);
        put(4095, 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) put(5, 1'b1, 1'b0);
        expect_report("R5", 1, 20, 1);

        // R6: partial window, then hold across more than a window
        d0 = done_seen;
        for (int i = 0; i < 3; i++) put(300, 1'b1, 1'b0);
        for (int i = 0; i < 12; i++) put(4000, 1'b1, 1'b1);
        put(0, 1'b0, 1'b0);
        @(negedge clk);
        check("R6 no done under hold", done_seen - d0, 0);
        check("R6 report untouched", int'(peak_value), 20);
        run_win({12'd1,12'd2,12'd90,12'd3,12'd4,12'd5,12'd6,12'd7});
        expect_report("R6 restart", 1, 90, 5);

        // R9: partial next window must not disturb the report
        for (int i = 0; i < 4; i++) put(3000, 1'b1, 1'b0);
        put(0, 1'b0, 1'b0);
        @(negedge clk);
        check("R9 stable mid-window peak", int'(peak_value), 90);
        check("R9 stable mid-window offset", int'(timing_offset), 5);
        for (int i = 0; i < 3; i++) put(1, 1'b1, 1'b0);
        put(2, 1'b1, 1'b0);
        expect_report("R9 R1 window spans idle", 1, 3000, 0);

        // R10: reset in mid-window clears report and restarts index
        for (int i = 0; i < 3; i++) put(500, 1'b1, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        corr_vld = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 mid reset peak", int'(peak_value), 0);
        check("R10 mid reset found", int'(peak_found), 0);
        run_win({12'd0,12'd0,12'd0,12'd0,12'd0,12'd0,12'd0,12'd77});
        expect_report("R10 after reset", 1, 77, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule